// File: doc/BRIEF.md
# BCD Calendar Date Counter

This block holds a calendar date as binary-coded decimal inside a single 32-bit word: a four-digit year, a two-digit month and a two-digit day of the month. A separate time-of-day block sends a one-cycle strobe once per day, and on each strobe the date moves forward by one day. The block handles months of 28, 29, 30 and 31 days and applies the Gregorian leap-year rule directly to the decimal year digits.

Software reaches the word through a one-register bus slave with no address lines. A write replaces the date, but any field written as all ones keeps its present value, so one field can be changed without reading the others first. Each bus request is acknowledged exactly one clock after it is presented. Stall is never raised.

Each cycle, an update selector picks one of five update kinds from the bus and the day strobe:
- UPD_HOLD: nothing happens.
- UPD_LOAD: a bus write.
- UPD_NEXT_DAY: the strobe arrives inside a month.
- UPD_NEXT_MONTH: the strobe arrives on the last day of a month other than December.
- UPD_NEXT_YEAR: the strobe arrives on December 31.

The selector moves from HOLD to any other kind in a single cycle, and from any kind back to HOLD. The date register is the only stored state.

Top module: `bcd_date_keeper`

## Requirements
- R1: While reset is asserted and just after it is released, the date reads as the parameter defaults (year 2000, month 01, day 01) and acknowledge is low.
- R2: The read word places the BCD day in bits 5:0, the BCD month in bits 12:8 and the BCD year in bits 29:16. Bits 31:30, 15:13 and 7:6 always read as zero.
- R3: A write (cycle, strobe and write-enable all high) loads the day from bits 5:0, the month from bits 12:8 and the year from bits 29:16. The new value can be read in the next cycle.
- R4: In a write, a field keeps its current value when its write byte or bytes are all ones: bits 7:0 equal to 8'hFF for the day, bits 15:8 equal to 8'hFF for the month, and bits 31:16 equal to 16'hFFFF for the year.
- R5: When the day strobe is high on a clock edge and no write is made, the day increases by one with a decimal carry (for example 09 becomes 10) if it is not the last day of the month.
- R6: After the last day of a month, the day becomes 01 and the month increases by one. Months 04, 06, 09 and 11 end on day 30. Months 01, 03, 05, 07, 08, 10 and 12 end on day 31.
- R7: February ends on day 29 in a leap year and on day 28 otherwise. A year is a leap year when it is divisible by 4, except that a year divisible by 100 must also be divisible by 400.
- R8: After December 31 the date becomes January 01 and the year increases by one with a decimal carry across all four digits (for example 1999 becomes 2000).
- R9: When a write and the day strobe fall in the same cycle, the write wins and the strobe is lost.
- R10: Acknowledge equals (cycle AND strobe) delayed by one clock. Stall is always zero.
- R11: A read request (write-enable low) and a cycle with no strobe and no write both leave the date unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| day_pulse | input | 1 | One-cycle strobe that advances the date by one day |
| bus_cyc | input | 1 | Bus cycle |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Bus write enable |
| bus_wdata | input | 32 | Bus write data |
| bus_ack | output | 1 | Acknowledge, one clock after a request |
| bus_stall | output | 1 | Stall, always zero |
| bus_rdata | output | 32 | Packed BCD date |

## Verification
Random valid dates, most of them close to the end of a month, are written and then advanced by a random number of day strobes. Each result is compared against a decimal calendar model, which separates ordinary day increments from month and year rollovers.

Directed cases cover:
- Century years (1900, 2000) and ordinary leap and non-leap years, which separate the divide-by-4, divide-by-100 and divide-by-400 branches of the leap-year rule.
- A day of 09, which exposes a missing decimal carry.
- Partial writes with all-ones fields, which show whether each field is masked on its own.
- A write made in the same cycle as a strobe, which shows the priority between the two.
- Read requests, which show that reads have no side effect.

// File: rtl/date_pkg.sv
package date_pkg;
    localparam int DAY_W  = 6;
    localparam int MON_W  = 5;
    localparam int YEAR_W = 14;
    localparam int DAY_LSB  = 0;
    localparam int MON_LSB  = 8;
    localparam int YEAR_LSB = 16;

    typedef enum logic [2:0] {
        UPD_HOLD,
        UPD_LOAD,
        UPD_NEXT_DAY,
        UPD_NEXT_MONTH,
        UPD_NEXT_YEAR
    } upd_e;

    // True when the two-digit BCD number tens:ones is a multiple of four.
    function automatic logic bcd_pair_div4(input logic [3:0] tens, input logic [3:0] ones);
        if (tens[0] == 1'b0)
            return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
        else
            return (ones == 4'd2) || (ones == 4'd6);
    endfunction
endpackage

// File: rtl/date_bcd_step.sv
module date_bcd_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] nxt
);
    localparam int DIGITS = (W + 3) / 4;

    logic [DIGITS-1:0] cy_in;

    assign cy_in[0] = 1'b1;

    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        if (i > 0) begin : g_cy
            assign cy_in[i] = cy_in[i-1] & (val[4*(i-1) +: 4] == 4'd9);
        end
        if (4*i + 4 <= W) begin : g_full
            always_comb begin
                if (!cy_in[i])
                    nxt[4*i +: 4] = val[4*i +: 4];
                else if (val[4*i +: 4] == 4'd9)
                    nxt[4*i +: 4] = 4'd0;
                else
                    nxt[4*i +: 4] = val[4*i +: 4] + 4'd1;
            end
        end else begin : g_part
            assign nxt[W-1:4*i] = val[W-1:4*i] + {{(W-4*i-1){1'b0}}, cy_in[i]};
        end
    end
endmodule

// File: rtl/date_month_len.sv
module date_month_len
    import date_pkg::*;
(
    input  logic [MON_W-1:0]  month,
    input  logic [YEAR_W-1:0] year,
    output logic [DAY_W-1:0]  last_day
);
    logic [3:0] y_one, y_ten, y_hun, y_tho;
    logic       leap;

    assign y_one = year[3:0];
    assign y_ten = year[7:4];
    assign y_hun = year[11:8];
    assign y_tho = {2'b00, year[13:12]};

    always_comb begin
        if ((y_ten != 4'd0) || (y_one != 4'd0))
            leap = bcd_pair_div4(y_ten, y_one);
        else
            leap = bcd_pair_div4(y_tho, y_hun);
    end

    always_comb begin
        unique case (month)
            5'h02:                      last_day = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
            default:                    last_day = 6'h31;
        endcase
    end
endmodule

// File: rtl/date_bus_ack.sv
module date_bus_ack (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic ack,
    output logic stall
);
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= req;
    end

    assign stall = 1'b0;
endmodule

// File: rtl/bcd_date_keeper.sv
module bcd_date_keeper
    import date_pkg::*;
#(
    parameter logic [15:0] RST_YEAR  = 16'h2000,
    parameter logic [7:0]  RST_MONTH = 8'h01,
    parameter logic [7:0]  RST_DAY   = 8'h01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        day_pulse,
    input  logic        bus_cyc,
    input  logic        bus_stb,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic        bus_ack,
    output logic        bus_stall,
    output logic [31:0] bus_rdata
);
    logic [DAY_W-1:0]  day_q,  day_d,  day_inc,  last_day;
    logic [MON_W-1:0]  mon_q,  mon_d,  mon_inc;
    logic [YEAR_W-1:0] year_q, year_d, year_inc;
    logic              wr_hit;
    upd_e              upd;

    assign wr_hit = bus_cyc & bus_stb & bus_we;

    date_bus_ack u_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (bus_cyc & bus_stb),
        .ack   (bus_ack),
        .stall (bus_stall)
    );

    date_month_len u_len (
        .month    (mon_q),
        .year     (year_q),
        .last_day (last_day)
    );

    date_bcd_step #(.W(DAY_W))  u_day_step  (.val(day_q),  .nxt(day_inc));
    date_bcd_step #(.W(MON_W))  u_mon_step  (.val(mon_q),  .nxt(mon_inc));
    date_bcd_step #(.W(YEAR_W)) u_year_step (.val(year_q), .nxt(year_inc));

    // Update selector: the write has priority over the day strobe.
    always_comb begin
        if (wr_hit)
            upd = UPD_LOAD;
        else if (!day_pulse)
            upd = UPD_HOLD;
        else if (day_q != last_day)
            upd = UPD_NEXT_DAY;
        else if (mon_q != 5'h12)
            upd = UPD_NEXT_MONTH;
        else
            upd = UPD_NEXT_YEAR;
    end

    always_comb begin
        day_d  = day_q;
        mon_d  = mon_q;
        year_d = year_q;
        unique case (upd)
            UPD_HOLD: ;
            UPD_LOAD: begin
                if (bus_wdata[7:0] != 8'hFF)
                    day_d = bus_wdata[DAY_LSB +: DAY_W];
                if (bus_wdata[15:8] != 8'hFF)
                    mon_d = bus_wdata[MON_LSB +: MON_W];
                if (bus_wdata[31:16] != 16'hFFFF)
                    year_d = bus_wdata[YEAR_LSB +: YEAR_W];
            end
            UPD_NEXT_DAY:   day_d = day_inc;
            UPD_NEXT_MONTH: begin
                day_d = 6'h01;
                mon_d = mon_inc;
            end
            UPD_NEXT_YEAR: begin
                day_d  = 6'h01;
                mon_d  = 5'h01;
                year_d = year_inc;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            day_q  <= RST_DAY[DAY_W-1:0];
            mon_q  <= RST_MONTH[MON_W-1:0];
            year_q <= RST_YEAR[YEAR_W-1:0];
        end else begin
            day_q  <= day_d;
            mon_q  <= mon_d;
            year_q <= year_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        bus_rdata[DAY_LSB  +: DAY_W]  = day_q;
        bus_rdata[MON_LSB  +: MON_W]  = mon_q;
        bus_rdata[YEAR_LSB +: YEAR_W] = year_q;
    end
endmodule

// File: rtl/date_keeper_chk.sv
module date_keeper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        day_pulse,
    input logic        bus_cyc,
    input logic        bus_stb,
    input logic        bus_we,
    input logic        bus_ack,
    input logic        bus_stall,
    input logic [31:0] bus_rdata
);
    logic wr;
    assign wr = bus_cyc & bus_stb & bus_we;

    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_stb) |=> bus_ack); // R10
    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cyc && bus_stb) |=> !bus_ack); // R10
    AST_STALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stall == 1'b0); // R10
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:30] == 2'b00 && bus_rdata[15:13] == 3'b000 && bus_rdata[7:6] == 2'b00); // R2
    AST_PULSE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (day_pulse && !wr) |=> bus_rdata != $past(bus_rdata)); // R5
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!day_pulse && !wr) |=> $stable(bus_rdata)); // R11
    AST_MONTH_ROLL_DAY1: assert property (@(posedge clk) disable iff (!rst_n)
        (day_pulse && !wr) |=> (bus_rdata[5:0] == 6'h01 || bus_rdata[12:8] == $past(bus_rdata[12:8]))); // R6
endmodule

bind bcd_date_keeper date_keeper_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .day_pulse (day_pulse),
    .bus_cyc   (bus_cyc),
    .bus_stb   (bus_stb),
    .bus_we    (bus_we),
    .bus_ack   (bus_ack),
    .bus_stall (bus_stall),
    .bus_rdata (bus_rdata)
);

// File: tb/bcd_date_keeper_tb_top.sv
module bcd_date_keeper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        day_pulse = 1'b0;
    logic        bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack, bus_stall;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    int my = 2000, mm = 1, md = 1;

    always #4 clk = ~clk;

    bcd_date_keeper dut_i (
        .clk(clk), .rst_n(rst_n), .day_pulse(day_pulse),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_stall(bus_stall),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] bcd2(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [15:0] bcd4(input int v);
        return {bcd2(v / 100), bcd2(v % 100)};
    endfunction

    function automatic logic [31:0] pack(input int y, input int m, input int d);
        return {2'b00, bcd4(y)[13:0], 3'b000, bcd2(m)[4:0], 2'b00, bcd2(d)[5:0]};
    endfunction

    function automatic bit is_leap(input int y);
        return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    endfunction

    function automatic int dim(input int m, input int y);
        if (m == 2) return is_leap(y) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_step();
        md++;
        if (md > dim(mm, my)) begin
            md = 1;
            mm++;
            if (mm > 12) begin
                mm = 1;
                my++;
            end
        end
    endtask

    task automatic bus_write(input logic [31:0] w);
        @(negedge clk);
        bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_wdata = w;
        @(negedge clk);
        bus_cyc = 0; bus_stb = 0; bus_we = 0;
    endtask

    task automatic set_date(input int y, input int m, input int d);
        bus_write(pack(y, m, d));
        my = y; mm = m; md = d;
    endtask

    task automatic pulse_once();
        @(negedge clk);
        day_pulse = 1;
        @(negedge clk);
        day_pulse = 0;
        model_step();
    endtask

    task automatic step_and_check(input string req, input int y, input int m, input int d);
        set_date(y, m, d);
        check(req, bus_rdata, pack(my, mm, md));
        pulse_once();
        check(req, bus_rdata, pack(my, mm, md));
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset date", bus_rdata, pack(2000, 1, 1));
        check("R1 reset ack", {31'd0, bus_ack}, 32'd0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", bus_rdata, pack(2000, 1, 1));

        // R3 plain write; R10 ack timing and stall
        @(negedge clk);
        bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_wdata = pack(2023, 6, 9);
        check("R10 stall", {31'd0, bus_stall}, 32'd0);
        @(negedge clk);
        check("R10 ack one clock later", {31'd0, bus_ack}, 32'd1);
        check("R3 write visible", bus_rdata, pack(2023, 6, 9));
        bus_cyc = 0; bus_stb = 0; bus_we = 0;
        @(negedge clk);
        check("R10 ack drops", {31'd0, bus_ack}, 32'd0);
        my = 2023; mm = 6; md = 9;

        // R5 decimal carry 09 -> 10
        pulse_once();
        check("R5 day 09 to 10", bus_rdata, pack(2023, 6, 10));

        // R2 layout with pad bits written as ones
        bus_write(32'hC023_E7C5 & ~32'h0000_0000);
        check("R2 pad bits zero", bus_rdata & 32'hC000_E0C0, 32'd0);
        check("R2 field positions", bus_rdata, {2'b00, 14'h0023, 3'b000, 5'h07, 2'b00, 6'h05});

        // R6 month ends
        step_and_check("R6 Apr 30", 2023, 4, 30);
        step_and_check("R6 Jan 31", 2023, 1, 31);
        step_and_check("R6 Nov 30", 2023, 11, 30);
        step_and_check("R6 Aug 30 stays Aug", 2023, 8, 30);
        // R7 leap rule
        step_and_check("R7 2000 Feb 28", 2000, 2, 28);
        check("R7 2000 leap day", bus_rdata, pack(2000, 2, 29));
        step_and_check("R7 1900 Feb 28", 1900, 2, 28);
        check("R7 1900 not leap", bus_rdata, pack(1900, 3, 1));
        step_and_check("R7 2024 Feb 29", 2024, 2, 29);
        step_and_check("R7 2023 Feb 28", 2023, 2, 28);
        step_and_check("R7 2100 Feb 28", 2100, 2, 28);
        // R8 year carry
        step_and_check("R8 1999 Dec 31", 1999, 12, 31);
        check("R8 new millennium", bus_rdata, pack(2000, 1, 1));
        step_and_check("R8 2099 Dec 31", 2099, 12, 31);

        // R4 partial writes
        set_date(2024, 2, 29);
        bus_write({16'hFFFF, 8'h07, 8'hFF});
        check("R4 month only", bus_rdata, pack(2024, 7, 29));
        bus_write({16'h2031, 8'hFF, 8'h15});
        check("R4 keep month", bus_rdata, pack(2031, 7, 15));
        bus_write(32'hFFFF_FFFF);
        check("R4 all kept", bus_rdata, pack(2031, 7, 15));
        my = 2031; mm = 7; md = 15;

        // R11 read and idle have no effect
        @(negedge clk);
        bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_wdata = pack(1111, 1, 1);
        @(negedge clk);
        bus_cyc = 0; bus_stb = 0;
        check("R11 read no effect", bus_rdata, pack(2031, 7, 15));
        check("R10 read ack", {31'd0, bus_ack}, 32'd1);
        repeat (5) @(negedge clk);
        check("R11 idle stable", bus_rdata, pack(2031, 7, 15));

        // R9 write beats strobe
        @(negedge clk);
        bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_wdata = pack(2010, 3, 31); day_pulse = 1;
        @(negedge clk);
        bus_cyc = 0; bus_stb = 0; bus_we = 0; day_pulse = 0;
        check("R9 write wins", bus_rdata, pack(2010, 3, 31));
        my = 2010; mm = 3; md = 31;

        // Random dates near month ends, R5 R6 R7 R8
        for (int i = 0; i < 150; i++) begin
            int y, m, d, n;
            y = int'($urandom_range(1, 3998));
            if ($urandom_range(0, 3) == 0) y = 100 * int'($urandom_range(1, 39));
            m = int'($urandom_range(1, 12));
            d = dim(m, y) - int'($urandom_range(0, 2));
            set_date(y, m, d);
            n = int'($urandom_range(1, 4));
            for (int k = 0; k < n; k++) pulse_once();
            check("R6 R7 R8 random advance", bus_rdata, pack(my, mm, md));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule